// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Register Bus

This block drives four output pins, each with its own rectangular waveform. Software sets each channel through a small memory-mapped register bus. Every channel has a control word, a period word and a duty word. The control word holds a run bit, a polarity bit and a ten-bit clock divider.

A running channel divides the work clock by its divider. It counts the divided ticks from zero up to period-1 and then starts again at zero. The pin is in its active state while the count is below the duty value. Polarity decides which pin level is active. A stopped channel holds its prescaler and counter at zero and parks its pin at the inactive level. One clock runs both the bus and the waveform logic.

Reads take one cycle: the data for a read request appears on the read-data port after the next clock edge and stays there until the next read request. Register writes take effect on the clock edge where they are issued.

Top module: `pulse_gen_bank`

## Requirements
- R1: Channel n (0..3) owns the byte offsets (n+1)*0x10 up to (n+1)*0x10+0xB. The control word is at +0x0, the period at +0x4 and the duty at +0x8. Address bits 1:0 are ignored. A write takes effect on the edge where it is issued. A read request returns the stored value on `bus_rdata` after the next edge.
- R2: Control word layout: bit 0 = run, bit 1 = polarity, bits 11:2 = divider. Bits 31:12 are not stored and always read as zero.
- R3: Unmapped offsets (0x00–0x0F, +0xC of any channel, and 0x50 and above) read as zero. Writes to them change no register.
- R4: While the run bit is 0, the pin sits at the inactive level: low when polarity is 1, high when polarity is 0. The prescaler and counter are held at zero, so a channel that is started again begins its waveform from count 0.
- R5: After the edge that sets the run bit, the pin value following the k-th later edge (k ≥ 1) is active exactly when ((k-1) / divider) mod period < duty.
- R6: With divider d, the counter advances once every d clock cycles. A divider field of 0 behaves as 1.
- R7: A duty value greater than or equal to a non-zero period keeps the pin active for every cycle. A period of 0 keeps the pin inactive. Both hold when the value is changed while the channel runs.
- R8: Polarity 1 makes high the active level. Polarity 0 makes low the active level and inverts the waveform.
- R9: The channels are independent. Writing or running one channel does not change another channel's pin.
- R10: After reset all registers read zero and all four pins are high (stopped, polarity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the waveform logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (when bus_sel is 1) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the request |
| pwm_out | output | 4 | Waveform pins, one per channel |

## Verification
Read data is due one edge after the read request. Every pin reacts one edge after the edge that stored the control, period or duty value it depends on, because the pin is registered behind the counter compare. Each expectation goes into the scoreboard tagged with the absolute cycle number at which it is due. The monitor compares an item only at the falling edge of that cycle, so several channels that start on different edges can be checked against their own waveforms at the same time.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

  // Control word field widths (field order is decoded by software)
  localparam int DIV_W = 10;

  typedef struct packed {
    logic [DIV_W-1:0] div;   // bits 11:2
    logic             pol;   // bit 1, 1 = high is active
    logic             run;   // bit 0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Word index inside a channel window (address bits 3:2)
  localparam logic [1:0] WORD_MODE   = 2'd0;
  localparam logic [1:0] WORD_PERIOD = 2'd1;
  localparam logic [1:0] WORD_DUTY   = 2'd2;

endpackage

// File: rtl/pgb_regfile.sv
module pgb_regfile
  import pgb_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output mode_t [N_CH-1:0]              mode_o,
  output logic  [N_CH-1:0][DATA_W-1:0]  period_o,
  output logic  [N_CH-1:0][DATA_W-1:0]  duty_o
);

  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       word;
  logic [N_CH-1:0]  ch_hit;
  logic             unused_low;

  assign blk        = bus_addr[ADDR_W-1:4];
  assign word       = bus_addr[3:2];
  assign unused_low = ^bus_addr[1:0];   // R1: byte lanes not decoded

  // R1/R3: channel n lives in window n+1; window 0 and windows past N_CH decode to nothing
  for (genvar c = 0; c < N_CH; c++) begin : g_hit
    assign ch_hit[c] = (blk == BLK_W'(c + 1));
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    mode_t             mode_q, mode_d;
    logic [DATA_W-1:0] per_q, per_d;
    logic [DATA_W-1:0] duty_q, duty_d;
    logic              wr_here;

    assign wr_here = bus_sel & bus_wr & ch_hit[c];

    always_comb begin
      mode_d = mode_q;
      per_d  = per_q;
      duty_d = duty_q;
      if (wr_here) begin
        case (word)
          WORD_MODE:   mode_d = mode_t'(bus_wdata[MODE_W-1:0]);  // R2: upper bits dropped
          WORD_PERIOD: per_d  = bus_wdata;
          WORD_DUTY:   duty_d = bus_wdata;
          default:     ;                                         // R3: +0xC ignored
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;   // R10
        per_q  <= '0;
        duty_q <= '0;
      end else if (wr_here) begin
        mode_q <= mode_d;
        per_q  <= per_d;
        duty_q <= duty_d;
      end
    end

    assign mode_o[c]   = mode_q;
    assign period_o[c] = per_q;
    assign duty_o[c]   = duty_q;
  end

  // Read path: decode now, register the result
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rd_req;

  assign rd_req = bus_sel & ~bus_wr;

  always_comb begin
    rd_mux = '0;                 // R3: unmapped reads give zero
    for (int c = 0; c < N_CH; c++) begin
      if (ch_hit[c]) begin
        case (word)
          WORD_MODE:   rd_mux = {{(DATA_W-MODE_W){1'b0}}, mode_o[c]};
          WORD_PERIOD: rd_mux = period_o[c];
          WORD_DUTY:   rd_mux = duty_o[c];
          default:     rd_mux = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_req) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pgb_prescale.sv
module pgb_prescale #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] pcnt_q, pcnt_d;

  // R6: a zero divider field behaves like one
  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  // ">=" also recovers when the divider is lowered below the running count
  assign tick_o = en_i && (pcnt_q >= last);

  always_comb begin
    if (!en_i || tick_o) pcnt_d = '0;   // R4: held at zero while stopped
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/pgb_counter.sv
module pgb_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [DATA_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              out_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] cnt_ext;
  logic              cnt_ld;
  logic              per_zero;
  logic              at_end;
  logic              active;
  logic              out_q, out_d;

  assign cnt_ext  = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
  assign per_zero = (period_i == '0);
  assign at_end   = !per_zero && (cnt_ext >= period_i - 1'b1);
  assign cnt_ld   = !en_i || tick_i;

  // R5: wrap to zero after period-1; R4: cleared while stopped
  always_comb begin
    if (!en_i)                   cnt_d = '0;
    else if (per_zero || at_end) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  // R5/R7: active below duty, never with a zero period
  assign active = en_i && !per_zero && (cnt_ext < duty_i);
  // R8: polarity picks the active level; R4: inactive level otherwise
  assign out_d  = active ? pol_i : ~pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;   // R10: stopped, polarity 0 after reset
    else        out_q <= out_d;
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

endmodule

// File: rtl/pulse_gen_bank.sv
module pulse_gen_bank
  import pgb_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   pwm_out
);

  mode_t [N_CH-1:0]             mode_w;
  logic  [N_CH-1:0][DATA_W-1:0] period_w;
  logic  [N_CH-1:0][DATA_W-1:0] duty_w;
  logic  [N_CH-1:0][CNT_W-1:0]  cnt_w;
  logic  [N_CH-1:0]             en_vec;
  logic  [N_CH-1:0]             pol_vec;
  logic  [N_CH-1:0]             tick_vec;

  pgb_regfile #(
    .N_CH   (N_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_o    (mode_w),
    .period_o  (period_w),
    .duty_o    (duty_w)
  );

  // R9: one independent prescaler and counter per channel
  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    assign en_vec[c]  = mode_w[c].run;
    assign pol_vec[c] = mode_w[c].pol;

    pgb_prescale #(
      .DIV_W (DIV_W)
    ) i_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_vec[c]),
      .div_i  (mode_w[c].div),
      .tick_o (tick_vec[c])
    );

    pgb_counter #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
    ) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_vec[c]),
      .pol_i    (pol_vec[c]),
      .tick_i   (tick_vec[c]),
      .period_i (period_w[c]),
      .duty_i   (duty_w[c]),
      .cnt_o    (cnt_w[c]),
      .out_o    (pwm_out[c])
    );
  end

endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic [N_CH-1:0]              pwm_out,
  input logic [N_CH-1:0]              en_vec,
  input logic [N_CH-1:0]              pol_vec,
  input logic [N_CH-1:0]              tick_vec,
  input logic [N_CH-1:0][CNT_W-1:0]   cnt_w,
  input logic [N_CH-1:0][DATA_W-1:0]  period_w,
  input logic [N_CH-1:0][DATA_W-1:0]  duty_w
);

  int   blk_i;
  logic mapped;
  logic mode_word;

  assign blk_i     = int'(bus_addr[ADDR_W-1:4]);
  assign mapped    = (blk_i >= 1) && (blk_i <= N_CH) && (bus_addr[3:2] != 2'd3);
  assign mode_word = mapped && (bus_addr[3:2] == 2'd0);

  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !mapped) |=> (bus_rdata == '0));

  // R2
  mode_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && mode_word) |=> (bus_rdata[DATA_W-1:12] == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_prop
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[i] |=> (pwm_out[i] == !$past(pol_vec[i])));

    // R7
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[i] && period_w[i] == '0) |=> (pwm_out[i] == !$past(pol_vec[i])));

    // R7
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[i] && period_w[i] != '0 && duty_w[i] >= period_w[i])
        |=> (pwm_out[i] == $past(pol_vec[i])));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[i] && !tick_vec[i]) |=> (cnt_w[i] == $past(cnt_w[i])));
  end

endmodule

bind pulse_gen_bank pgb_checker #(
  .N_CH   (N_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) i_pgb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .en_vec    (en_vec),
  .pol_vec   (pol_vec),
  .tick_vec  (tick_vec),
  .cnt_w     (cnt_w),
  .period_w  (period_w),
  .duty_w    (duty_w)
);

// File: tb/test_pulse_gen_bank.sv
`timescale 1ns/1ps
module test_pulse_gen_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  always #2.5 clk = ~clk;   // 200 MHz

  pulse_gen_bank i_pulse_gen_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  typedef struct {
    int          due;
    bit          is_pin;
    int          ch;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    cyc    = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every item due in this cycle
  always @(negedge clk) begin
    int j;
    item_t it;
    logic [31:0] act;
    j = 0;
    while (j < sbq.size()) begin
      if (sbq[j].due == cyc) begin
        it  = sbq[j];
        act = it.is_pin ? {31'b0, pwm_out[it.ch]} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s ch%0d cycle %0d actual %0h expected %0h",
                   it.tag, it.is_pin ? "pin" : "rdata", it.ch, cyc, act, it.exp);
        end
        sbq.delete(j);
      end else begin
        j++;
      end
    end
  end

  function automatic logic [31:0] mode_word(input bit run, input bit pol, input int div);
    return (32'(div) << 2) | (32'(pol) << 1) | 32'(run);
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.due = cyc + 1; it.is_pin = 1'b0; it.ch = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Pin values after edges base+k0 .. base+k1, counted from the run edge (R5)
  task automatic push_wave(input int ch, input bit pol, input int div, input int per,
                           input int duty, input int k0, input int k1, input int base,
                           input string tag);
    for (int k = k0; k <= k1; k++) begin
      item_t it;
      int d;
      int c;
      bit act;
      d   = (div == 0) ? 1 : div;
      c   = (per == 0) ? 0 : ((k - 1) / d) % per;
      act = (per != 0) && (c < duty);
      it.due = base + k; it.is_pin = 1'b1; it.ch = ch;
      it.exp = act ? 32'(pol) : 32'(!pol); it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic push_hold(input int ch, input bit val, input int n, input string tag);
    for (int k = 1; k <= n; k++) begin
      item_t it;
      it.due = cyc + k; it.is_pin = 1'b1; it.ch = ch; it.exp = 32'(val); it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, b1, b3;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    for (int c = 0; c < 4; c++) push_hold(c, 1'b1, 3, "R10");
    wait_cycles(4);
    bus_read_expect(8'h10, 32'h0, "R10");
    bus_read_expect(8'h48, 32'h0, "R10");

    // R1: register map and read-back
    for (int c = 0; c < 4; c++) begin
      bus_write(8'((c + 1) * 16 + 4), 32'h100 + 32'(c));
      bus_write(8'((c + 1) * 16 + 8), 32'h200 + 32'(c));
    end
    for (int c = 0; c < 4; c++) begin
      bus_read_expect(8'((c + 1) * 16 + 4), 32'h100 + 32'(c), "R1");
      bus_read_expect(8'((c + 1) * 16 + 8), 32'h200 + 32'(c), "R1");
    end
    bus_write(8'h34, 32'hCAFE_0123);
    bus_read_expect(8'h35, 32'hCAFE_0123, "R1");

    // R2: control word fields, upper bits dropped
    bus_write(8'h20, 32'hFFFF_F00E);
    push_hold(1, 1'b0, 3, "R4");   // stopped, polarity 1 -> low
    bus_read_expect(8'h20, 32'h0000_000E, "R2");
    bus_write(8'h20, mode_word(0, 1, 1023));
    bus_read_expect(8'h20, 32'h0000_0FFE, "R2");

    // R3: unmapped offsets
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'h1111_1111);
    bus_write(8'h4C, 32'h2222_2222);
    bus_write(8'h50, 32'h3333_3333);
    bus_write(8'hFC, 32'h4444_4444);
    bus_read_expect(8'h00, 32'h0, "R3");
    bus_read_expect(8'h1C, 32'h0, "R3");
    bus_read_expect(8'h50, 32'h0, "R3");
    bus_read_expect(8'hFC, 32'h0, "R3");
    bus_read_expect(8'h10, 32'h0, "R3");
    bus_read_expect(8'h14, 32'h100, "R3");
    bus_read_expect(8'h48, 32'h203, "R3");

    // R5: basic waveform, divider 1, period 5, duty 2
    bus_write(8'h14, 32'd5);
    bus_write(8'h18, 32'd2);
    bus_write(8'h10, mode_word(1, 1, 1));
    push_wave(0, 1'b1, 1, 5, 2, 1, 15, cyc, "R5");
    wait_cycles(16);

    // R4: stop drives inactive level; restart begins at count 0
    bus_write(8'h10, mode_word(0, 1, 3));
    push_hold(0, 1'b0, 3, "R4");
    wait_cycles(3);
    bus_write(8'h14, 32'd3);
    bus_write(8'h18, 32'd1);
    bus_write(8'h10, mode_word(1, 1, 3));
    push_wave(0, 1'b1, 3, 3, 1, 1, 20, cyc, "R6");
    wait_cycles(21);

    // R6: divider 0 acts as 1
    bus_write(8'h10, mode_word(0, 1, 0));
    bus_write(8'h10, mode_word(1, 1, 0));
    b0 = cyc;
    push_wave(0, 1'b1, 0, 3, 1, 1, 9, b0, "R6");
    wait_cycles(10);

    // R7: duty >= period, then period 0, while running
    bus_write(8'h34, 32'd4);
    bus_write(8'h38, 32'd4);
    bus_write(8'h30, mode_word(1, 1, 1));
    push_wave(2, 1'b1, 1, 4, 4, 1, 10, cyc, "R7");
    wait_cycles(11);
    bus_write(8'h38, 32'd9);
    push_hold(2, 1'b1, 6, "R7");
    wait_cycles(7);
    bus_write(8'h34, 32'd0);
    push_hold(2, 1'b0, 6, "R7");
    wait_cycles(7);

    // R8: inverted polarity, divider 2, period 4, duty 1
    bus_write(8'h44, 32'd4);
    bus_write(8'h48, 32'd1);
    bus_write(8'h40, mode_word(1, 0, 2));
    b3 = cyc;
    push_wave(3, 1'b0, 2, 4, 1, 1, 16, b3, "R8");
    wait_cycles(17);

    // R9: start channel 1 while 0, 2 and 3 keep running undisturbed
    bus_write(8'h24, 32'd5);
    bus_write(8'h28, 32'd3);
    bus_write(8'h20, mode_word(1, 1, 2));
    b1 = cyc;
    push_wave(1, 1'b1, 2, 5, 3, 1, 20, b1, "R9");
    push_wave(3, 1'b0, 2, 4, 1, b1 - b3 + 1, b1 - b3 + 20, b3, "R9");
    push_wave(0, 1'b1, 0, 3, 1, b1 - b0 + 1, b1 - b0 + 20, b0, "R9");
    push_hold(2, 1'b0, 20, "R9");
    wait_cycles(22);

    if (sbq.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard actual %0d expected 0 pending items", sbq.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule